// File: doc/BRIEF.md
# Frame Skew Meter

This block measures how late the frame boundary of one chosen serial input lags behind the local frame reference. It counts rising edges of the master clock, starting from the reference pulse and ending when the chosen input first falls. Two samplers watch the chosen input, one on each clock edge, so the result carries one extra bit that gives half-period resolution.

Software picks one of the inputs through a 5-bit field of a single 16-bit status word. A separate start level arms the measurement. The word also returns a completion flag, the phase bit and the 9-bit count. Dropping the start level clears the result so that a new run can begin.

Top module: `frame_skew_meter`

## Requirements
- R1: The status word reads at address 1 as {select[15:11], done[10], phase[9], count[8:0]}. Any other address reads 0x0000.
- R2: After reset the status word reads 0x0000.
- R3: A write to address 1 loads bits 15:11 into the select field. Written bits 10:0 are ignored. A write to any other address changes nothing.
- R4: A rising start level arms the unit and clears the count. The first reference pulse sampled on a rising clock edge P0 after arming starts the count. A fall of the selected input in the high half-period after rising edge Pj (j >= 0) ends with count j+1. A fall in the low half-period after Pj ends with count j+2.
- R5: The phase bit is 1 when the rising-edge sampler caught the low level first (fall in a low half-period). It is 0 when the falling-edge sampler caught it first (fall in a high half-period).
- R6: When the measurement ends, the done flag reads 1. Count and phase then stay frozen while start stays high, whatever the input or the reference pulse does.
- R7: If no fall arrives, the count stops at 511 and the unit reports done with phase 0.
- R8: When start goes from 1 to 0, bits 10:0 read zero from the next cycle on. The select field is kept.
- R9: Only the input named by the select field can end a measurement. Falls on the other inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both edges sample the selected input |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_ref_i | input | 1 | Local frame reference pulse |
| eval_i | input | 32 | Evaluation inputs, one per serial stream |
| start_i | input | 1 | Start level; rising arms, falling clears |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from the address |

## Verification
The bench builds the block with its default parameters: 32 inputs, a 9-bit count and the status word at address 1. With these values it reaches the two ends of the select range (0 and 31). It also reaches the saturation limit of 511, which takes about 520 cycles. Falls are placed in both half-periods after several rising edges, so the count and the phase bit are checked together against the arrival time.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } fsk_state_e;
endpackage

// File: rtl/fsk_sync.sv
// Two-flop synchronizer plus history flop; reports a falling level.
module fsk_sync #(
  parameter bit ON_FALL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic fall_o
);
  logic [2:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], d_i};
  end

  generate
    if (ON_FALL) begin : g_neg
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end
    end else begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end
    end
  endgenerate

  assign fall_o = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/fsk_core.sv
module fsk_core
  import fsk_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ref_i,
  input  logic             pos_fall_i,
  input  logic             neg_fall_i,
  output logic             done_o,
  output logic             phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fsk_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             start_q;
  logic             start_rise, start_drop;

  assign start_rise = start_i & ~start_q;
  assign start_drop = ~start_i & start_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (start_drop) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (start_rise) begin
      state_d = ST_ARMED;
      cnt_d   = '0;
      phase_d = 1'b0;
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (ref_i) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
          end
        end
        ST_COUNT: begin
          if (pos_fall_i) begin
            state_d = ST_DONE;
            phase_d = 1'b1;
          end else if (neg_fall_i) begin
            state_d = ST_DONE;
            phase_d = 1'b0;
          end else if (cnt_q == CNT_MAX) begin
            state_d = ST_DONE;
            phase_d = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      start_q <= start_i;
    end
  end

  assign done_o  = (state_q == ST_DONE);
  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  a_r8_clear_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !start_i) |=> (!done_o && !phase_o && cnt_o == '0));

  a_r6_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_q && start_i) |=> (done_o && $stable(cnt_o) && $stable(phase_o)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && cnt_q == CNT_MAX && start_q && start_i)
      |=> (done_o && cnt_o == CNT_MAX));

  a_r4_done_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state_q) == ST_COUNT));
endmodule

// File: rtl/frame_skew_meter.sv
module frame_skew_meter
  import fsk_pkg::*;
#(
  parameter int N_IN     = 32,
  parameter int CNT_W    = 9,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  frame_ref_i,
  input  logic [N_IN-1:0]                       eval_i,
  input  logic                                  start_i,
  input  logic [ADDR_W-1:0]                     reg_addr_i,
  input  logic                                  reg_wr_i,
  input  logic [$clog2(N_IN)+CNT_W+1:0]         reg_wdata_i,
  output logic [$clog2(N_IN)+CNT_W+1:0]         reg_rdata_o
);
  localparam int SEL_W  = $clog2(N_IN);
  localparam int DATA_W = SEL_W + CNT_W + 2;

  logic              rs1_q, rs2_q;
  logic              rst_sync_n;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              wr_hit, rd_hit;
  logic              eval_sel;
  logic              pos_fall, neg_fall;
  logic              done, phase;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-SEL_W-1:0] unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  assign wr_hit = reg_wr_i && (reg_addr_i == ADDR_W'(REG_ADDR));
  assign rd_hit = (reg_addr_i == ADDR_W'(REG_ADDR));
  assign unused_wdata = reg_wdata_i[DATA_W-SEL_W-1:0];

  always_comb begin
    sel_d = sel_q;
    if (wr_hit) sel_d = reg_wdata_i[DATA_W-1 -: SEL_W];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_q <= '0;
    else             sel_q <= sel_d;
  end

  assign eval_sel = eval_i[sel_q];

  fsk_sync #(.ON_FALL(1'b0)) u_sync_rise (
    .clk(clk), .rst_n(rst_sync_n), .d_i(eval_sel), .fall_o(pos_fall));

  fsk_sync #(.ON_FALL(1'b1)) u_sync_fall (
    .clk(clk), .rst_n(rst_sync_n), .d_i(eval_sel), .fall_o(neg_fall));

  fsk_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .ref_i(frame_ref_i),
    .pos_fall_i(pos_fall), .neg_fall_i(neg_fall),
    .done_o(done), .phase_o(phase), .cnt_o(cnt));

  assign reg_rdata_o = rd_hit ? {sel_q, done, phase, cnt} : '0;

  a_r3_select_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_hit |=> (sel_q == $past(reg_wdata_i[DATA_W-1 -: SEL_W])));

  a_r3_select_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_hit |=> $stable(sel_q));
endmodule

// File: tb/frame_skew_meter_test.sv
`timescale 1ns/1ps
module frame_skew_meter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_ref = 1'b0;
  logic [31:0] eval = '1;
  logic        start = 1'b0;
  logic [3:0]  addr = 4'd1;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic        done_prev = 1'b0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  frame_skew_meter uut (
    .clk(clk), .rst_n(rst_n), .frame_ref_i(frame_ref), .eval_i(eval),
    .start_i(start), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 4'd1;
  endtask

  // Scoreboard monitor: compare on each rise of the done flag.
  always @(posedge clk) begin
    #1;
    if (rst_n && addr == 4'd1) begin
      if (rdata[10] && !done_prev) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected completion actual=%h expected=none", rdata);
        end else begin
          check("R4/R5/R7 result", rdata, exp_q.pop_front());
        end
      end
      done_prev = rdata[10];
    end
  end

  // j < 0 means no fall at all (saturation run).
  task automatic measure(input int sel, input bit high_half, input int j, input int distract);
    logic [15:0] frozen;
    logic [8:0]  ecnt;
    reg_write(4'd1, 16'(sel) << 11);
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    @(negedge clk) frame_ref = 1'b1;
    fork
      begin @(posedge clk); #1 frame_ref = 1'b0; end
    join_none
    if (distract >= 0) begin
      fork
        begin @(posedge clk); @(posedge clk); #1 eval[distract] = 1'b0; end
      join_none
    end
    if (j < 0) ecnt = 9'd511;
    else       ecnt = high_half ? 9'(j + 1) : 9'(j + 2);
    exp_q.push_back({5'(sel), 1'b1, (j >= 0) ? !high_half : 1'b0, ecnt});
    @(posedge clk); // P0
    if (j >= 0) begin
      repeat (j) @(posedge clk);
      #(high_half ? 1 : 3) eval[sel] = 1'b0;
      repeat (8) @(negedge clk);
    end else begin
      repeat (530) @(negedge clk);
    end
    // R6: further activity must not disturb the held result.
    frozen = rdata;
    eval[sel] = 1'b1;
    repeat (4) @(negedge clk);
    eval[sel] = 1'b0;
    frame_ref = 1'b1;
    @(negedge clk) frame_ref = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 frozen", rdata, frozen);
    eval = '1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R8 clear on drop", rdata, {5'(sel), 11'd0});
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 reset value", rdata, 16'h0000);

    reg_write(4'd1, 16'hFFFF);
    @(negedge clk);
    check("R3 write only select", rdata, 16'hF800);
    reg_write(4'd2, 16'h0000);
    @(negedge clk);
    check("R3 other address ignored", rdata, 16'hF800);
    addr = 4'd2;
    #1 check("R1 other address reads zero", rdata, 16'h0000);
    @(negedge clk) addr = 4'd1;
    #1 check("R1 layout select field", rdata, 16'hF800);

    measure(0, 1'b1, 0, -1);   // R4 R5 high half
    measure(31, 1'b0, 0, -1);  // R4 R5 low half
    measure(7, 1'b1, 10, -1);  // R4
    measure(18, 1'b0, 40, -1); // R4 R5
    measure(5, 1'b0, 3, 6);    // R9 unselected input ignored
    measure(9, 1'b0, -1, -1);  // R7 saturation

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6: missing completions actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule